// File: doc/BRIEF.md
# Handheld CPU Memory Map with DMA Restriction

This block sits between the CPU of an 8-bit handheld and its memories. For each 16-bit CPU address it picks a target (boot ROM overlay, cartridge, banked video RAM, banked work RAM, sprite attribute RAM, I/O registers or high RAM) and drives a target code, a memory index and a single write-enable pulse to that memory. The memories are outside the block and return their read bytes on one input per target. The block selects the right byte and holds it in a register.

Access rules from the video unit decide whether video RAM and sprite RAM may be touched. A blocked read returns a fixed byte and a blocked write is dropped. While sprite DMA runs, the CPU sees only a reduced map. Reads outside that map return the byte currently on the DMA bus, and writes outside it are discarded. The space between sprite RAM and the I/O registers behaves differently in mono and in colour mode. The boot ROM overlay covers one range in mono mode and two separate ranges in colour mode.

Top module: `hh_mem_map`

## Requirements
- R1: While rst_n is low at a rising clock edge, cpu_rdata becomes 0x00, and mem_we is low for as long as rst_n is low.
- R2: A read presented with cpu_rd high appears on cpu_rdata after the next rising edge. While cpu_rd is low, cpu_rdata keeps its value. mem_tgt shows the target code only while the current access is granted, and 0 otherwise. Target codes: 0 none, 1 boot ROM, 2 cartridge, 3 video RAM, 4 work RAM, 5 sprite RAM, 6 I/O, 7 high RAM. A granted read returns the byte on the rdata input of that target.
- R3: Each rising of cpu_wr raises mem_we for exactly one cycle, the first cycle in which cpu_wr is high, and only if the write is granted. mem_wdata equals cpu_wdata.
- R4: Outside DMA, 0x0000-0x00FF maps to the boot ROM (index = address) while boot_done is 0. In colour mode with boot_done 0, 0x0200-0x08FF also maps to the boot ROM. All other addresses in 0x0000-0x7FFF, and 0xA000-0xBFFF, go to the cartridge (index = address). Writes aimed at the boot ROM are dropped.
- R5: Outside DMA, 0x8000-0x9FFF maps to video RAM with index vram_bank*0x2000 + (address - 0x8000). Reads return 0xFF when vram_rd_ok is 0. Writes are dropped when vram_wr_ok is 0.
- R6: 0xC000-0xFDFF maps to work RAM with index (address & 0xFFF) + bank*0x1000 when address bit 12 is set, and (address & 0xFFF) when it is clear. bank is wram_bank, except that 0 counts as 1, and in mono mode bank is always 1.
- R7: Outside DMA, 0xFE00-0xFE9F maps to sprite RAM with index address - 0xFE00. Reads are gated by oam_rd_ok, returning 0xFF when blocked. Writes are gated by oam_wr_ok.
- R8: Outside DMA, for 0xFEA0-0xFEFF in mono mode, reads return 0x00 when oam_rd_ok is 1 and 0xFF when it is 0, and writes are dropped. In colour mode the same range maps to sprite RAM index 0x80 | (address & 0x0F), gated as in R7.
- R9: 0xFF00-0xFF7F and 0xFFFF map to I/O with index address - 0xFF00. 0xFF80-0xFFFE maps to high RAM with index address - 0xFF80.
- R10: During DMA, a read in 0x0000-0x7FFF returns 0xFF when dma_src_hi < 0x80, and otherwise returns cartridge data. Writes there are dropped.
- R11: During DMA, the following stay reachable: 0xA000-0xBFFF goes to the cartridge in colour mode only; 0xE000-0xFDFF goes to work RAM as in R6; 0xFE00-0xFE9F goes to sprite RAM only while dma_oam_ok is 1 (otherwise reads give 0xFF and writes are dropped); and 0xFF00-0xFFFF is mapped as in R9.
- R12: During DMA, a read of any other address returns dma_byte, and a write there is dropped with mem_tgt 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe (level) |
| cpu_wdata | input | 8 | Write data |
| dma_active | input | 1 | Sprite DMA is running |
| dma_src_hi | input | 8 | High byte of DMA source address |
| dma_byte | input | 8 | Byte currently on the DMA bus |
| dma_oam_ok | input | 1 | Sprite RAM reachable during DMA |
| oam_rd_ok | input | 1 | Sprite RAM read permit |
| oam_wr_ok | input | 1 | Sprite RAM write permit |
| vram_rd_ok | input | 1 | Video RAM read permit |
| vram_wr_ok | input | 1 | Video RAM write permit |
| vram_bank | input | VBANK_W (1) | Video RAM bank |
| wram_bank | input | WBANK_W (3) | Work RAM bank register |
| boot_done | input | 1 | Boot ROM overlay disabled |
| color_mode | input | 1 | Colour console mode |
| boot_rdata | input | 8 | Boot ROM read byte |
| cart_rdata | input | 8 | Cartridge read byte |
| vram_rdata | input | 8 | Video RAM read byte |
| wram_rdata | input | 8 | Work RAM read byte |
| oam_rdata | input | 8 | Sprite RAM read byte |
| io_rdata | input | 8 | I/O register read byte |
| hram_rdata | input | 8 | High RAM read byte |
| mem_tgt | output | 3 | Granted target code |
| mem_idx | output | IDX_W (16) | Index into the target |
| mem_we | output | 1 | Write-enable pulse |
| mem_wdata | output | 8 | Write data to the target |
| cpu_rdata | output | 8 | Registered read data |

## Verification
The hardest state to reach from the ports is the DMA map, because its outcome depends on several inputs together: dma_src_hi, colour mode, the DMA sprite permit and the value on the DMA bus. Because the DMA engine is outside the block, the bench drives these inputs directly. It holds each combination constant and sweeps a stride through the whole address space, plus every region edge. The memories are modelled as arithmetic functions of target and index. As a result, a wrong bank, a wrong index or a wrong target each produces a different byte from the expected one.

// File: rtl/hh_map_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the handheld memory map: target codes.
package hh_map_pkg;
    typedef enum logic [2:0] {
        T_NONE = 3'd0,
        T_BOOT = 3'd1,
        T_CART = 3'd2,
        T_VRAM = 3'd3,
        T_WRAM = 3'd4,
        T_OAM  = 3'd5,
        T_IO   = 3'd6,
        T_HRAM = 3'd7
    } tgt_e;

    localparam int NUM_TGT = 8;
endpackage

// File: rtl/hh_map_decode.sv
`timescale 1ns/1ps
// Address decoder: maps a CPU address to a target, an index, separate read and
// write grants, and the constant byte returned when a read is not granted.
// It is purely combinational. The caller gates the outputs with the strobes.
module hh_map_decode
    import hh_map_pkg::*;
#(
    parameter int VBANK_W = 1,
    parameter int WBANK_W = 3,
    parameter int IDX_W   = 16
) (
    input  logic [15:0]        addr,
    input  logic               dma_active,
    input  logic [7:0]         dma_src_hi,
    input  logic [7:0]         dma_byte,
    input  logic               dma_oam_ok,
    input  logic               oam_rd_ok,
    input  logic               oam_wr_ok,
    input  logic               vram_rd_ok,
    input  logic               vram_wr_ok,
    input  logic [VBANK_W-1:0] vram_bank,
    input  logic [WBANK_W-1:0] wram_bank,
    input  logic               boot_done,
    input  logic               color_mode,
    output tgt_e               tgt,
    output logic [IDX_W-1:0]   idx,
    output logic               rd_grant,
    output logic               wr_grant,
    output logic [7:0]         cval
);
    logic [WBANK_W-1:0] bank_eff;
    logic [IDX_W-1:0]   wram_idx;
    logic               boot_hit;

    // Effective work RAM bank: 0 aliases to 1, and mono mode is fixed at 1.
    always_comb begin
        if (color_mode && (wram_bank != '0)) bank_eff = wram_bank;
        else                                 bank_eff = WBANK_W'(1);
    end

    // Work RAM index, shared by the main window and its echo.
    always_comb begin
        if (addr[12]) wram_idx = IDX_W'({bank_eff, addr[11:0]});
        else          wram_idx = IDX_W'(addr[11:0]);
    end

    // Boot overlay hit: low page always, upper split range only in colour mode.
    always_comb begin
        boot_hit = !boot_done &&
                   ((addr < 16'h0100) ||
                    (color_mode && (addr >= 16'h0200) && (addr < 16'h0900)));
    end

    // Main region decode, restricted map first when DMA runs.
    always_comb begin
        tgt      = T_NONE;
        idx      = '0;
        rd_grant = 1'b0;
        wr_grant = 1'b0;
        cval     = 8'hFF;
        if (dma_active) begin
            if (addr < 16'h8000) begin
                if (dma_src_hi >= 8'h80) begin
                    tgt      = T_CART;
                    idx      = IDX_W'(addr);
                    rd_grant = 1'b1;
                end
            end else if ((addr >= 16'hA000) && (addr < 16'hC000) && color_mode) begin
                tgt      = T_CART;
                idx      = IDX_W'(addr);
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else if ((addr >= 16'hE000) && (addr < 16'hFE00)) begin
                tgt      = T_WRAM;
                idx      = wram_idx;
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else if ((addr >= 16'hFE00) && (addr < 16'hFEA0)) begin
                if (dma_oam_ok) begin
                    tgt      = T_OAM;
                    idx      = IDX_W'(addr[7:0]);
                    rd_grant = 1'b1;
                    wr_grant = 1'b1;
                end
            end else if ((addr >= 16'hFF80) && (addr != 16'hFFFF)) begin
                tgt      = T_HRAM;
                idx      = IDX_W'(addr[6:0]);
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else if (addr >= 16'hFF00) begin
                tgt      = T_IO;
                idx      = IDX_W'(addr[7:0]);
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else begin
                cval = dma_byte;
            end
        end else begin
            if (addr < 16'h8000) begin
                tgt      = boot_hit ? T_BOOT : T_CART;
                idx      = IDX_W'(addr);
                rd_grant = 1'b1;
                wr_grant = !boot_hit;
            end else if (addr < 16'hA000) begin
                tgt      = T_VRAM;
                idx      = IDX_W'({vram_bank, addr[12:0]});
                rd_grant = vram_rd_ok;
                wr_grant = vram_wr_ok;
            end else if (addr < 16'hC000) begin
                tgt      = T_CART;
                idx      = IDX_W'(addr);
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else if (addr < 16'hFE00) begin
                tgt      = T_WRAM;
                idx      = wram_idx;
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else if (addr < 16'hFEA0) begin
                tgt      = T_OAM;
                idx      = IDX_W'(addr[7:0]);
                rd_grant = oam_rd_ok;
                wr_grant = oam_wr_ok;
            end else if (addr < 16'hFF00) begin
                if (color_mode) begin
                    tgt      = T_OAM;
                    idx      = IDX_W'({4'h8, addr[3:0]});
                    rd_grant = oam_rd_ok;
                    wr_grant = oam_wr_ok;
                end else begin
                    cval = oam_rd_ok ? 8'h00 : 8'hFF;
                end
            end else if ((addr >= 16'hFF80) && (addr != 16'hFFFF)) begin
                tgt      = T_HRAM;
                idx      = IDX_W'(addr[6:0]);
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end else begin
                tgt      = T_IO;
                idx      = IDX_W'(addr[7:0]);
                rd_grant = 1'b1;
                wr_grant = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hh_rd_stage.sv
`timescale 1ns/1ps
// Read stage: selects the granted target's byte or the decode constant, and
// registers it on a read strobe. It holds its value otherwise.
module hh_rd_stage
    import hh_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cpu_rd,
    input  logic                            rd_grant,
    input  tgt_e                            tgt,
    input  logic [DATA_W-1:0]               cval,
    input  logic [NUM_TGT-1:0][DATA_W-1:0]  src,
    output logic [DATA_W-1:0]               rdata
);
    logic [DATA_W-1:0] sel;

    // Pick the byte a read of this cycle returns.
    always_comb sel = rd_grant ? src[tgt] : cval;

    // Capture the byte on a read strobe, and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cpu_rd) rdata <= sel;
    end
endmodule

// File: rtl/hh_wr_pulse.sv
`timescale 1ns/1ps
// Write edge detector: flags the first cycle of each write strobe. It assumes
// the strobe is a level that stays high for one or more cycles.
module hh_wr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_wr,
    output logic first
);
    logic wr_q;

    // Remember the previous strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= cpu_wr;
    end

    // High only in the first strobe cycle, and never during reset.
    always_comb first = rst_n && cpu_wr && !wr_q;
endmodule

// File: rtl/hh_mem_map.sv
`timescale 1ns/1ps
// Top of the handheld CPU memory map. Memories are external: this block drives
// target, index and write pulse, and registers the returned read byte.
// It assumes cpu_rd and cpu_wr are not asserted together.
module hh_mem_map
    import hh_map_pkg::*;
#(
    parameter int VBANK_W = 1,
    parameter int WBANK_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [7:0]         cpu_wdata,
    input  logic               dma_active,
    input  logic [7:0]         dma_src_hi,
    input  logic [7:0]         dma_byte,
    input  logic               dma_oam_ok,
    input  logic               oam_rd_ok,
    input  logic               oam_wr_ok,
    input  logic               vram_rd_ok,
    input  logic               vram_wr_ok,
    input  logic [VBANK_W-1:0] vram_bank,
    input  logic [WBANK_W-1:0] wram_bank,
    input  logic               boot_done,
    input  logic               color_mode,
    input  logic [7:0]         boot_rdata,
    input  logic [7:0]         cart_rdata,
    input  logic [7:0]         vram_rdata,
    input  logic [7:0]         wram_rdata,
    input  logic [7:0]         oam_rdata,
    input  logic [7:0]         io_rdata,
    input  logic [7:0]         hram_rdata,
    output logic [2:0]         mem_tgt,
    output logic [((13+VBANK_W) > (12+WBANK_W) ?
                   ((13+VBANK_W) > 16 ? 13+VBANK_W : 16) :
                   ((12+WBANK_W) > 16 ? 12+WBANK_W : 16))-1:0] mem_idx,
    output logic               mem_we,
    output logic [7:0]         mem_wdata,
    output logic [7:0]         cpu_rdata
);
    localparam int VR_W  = 13 + VBANK_W;
    localparam int WR_W  = 12 + WBANK_W;
    localparam int IDX_W = (VR_W > WR_W) ? ((VR_W > 16) ? VR_W : 16)
                                         : ((WR_W > 16) ? WR_W : 16);

    tgt_e                      dec_tgt;
    logic [IDX_W-1:0]          dec_idx;
    logic                      rd_grant;
    logic                      wr_grant;
    logic [7:0]                cval;
    logic                      wr_first;
    logic [NUM_TGT-1:0][7:0]   src;

    hh_map_decode #(
        .VBANK_W (VBANK_W),
        .WBANK_W (WBANK_W),
        .IDX_W   (IDX_W)
    ) dec_i (
        .addr       (cpu_addr),
        .dma_active (dma_active),
        .dma_src_hi (dma_src_hi),
        .dma_byte   (dma_byte),
        .dma_oam_ok (dma_oam_ok),
        .oam_rd_ok  (oam_rd_ok),
        .oam_wr_ok  (oam_wr_ok),
        .vram_rd_ok (vram_rd_ok),
        .vram_wr_ok (vram_wr_ok),
        .vram_bank  (vram_bank),
        .wram_bank  (wram_bank),
        .boot_done  (boot_done),
        .color_mode (color_mode),
        .tgt        (dec_tgt),
        .idx        (dec_idx),
        .rd_grant   (rd_grant),
        .wr_grant   (wr_grant),
        .cval       (cval)
    );

    // Gather the per-target read bytes in target-code order.
    always_comb begin
        src[T_NONE] = 8'hFF;
        src[T_BOOT] = boot_rdata;
        src[T_CART] = cart_rdata;
        src[T_VRAM] = vram_rdata;
        src[T_WRAM] = wram_rdata;
        src[T_OAM]  = oam_rdata;
        src[T_IO]   = io_rdata;
        src[T_HRAM] = hram_rdata;
    end

    hh_rd_stage #(
        .DATA_W (8)
    ) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_rd   (cpu_rd),
        .rd_grant (rd_grant),
        .tgt      (dec_tgt),
        .cval     (cval),
        .src      (src),
        .rdata    (cpu_rdata)
    );

    hh_wr_pulse wr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_wr (cpu_wr),
        .first  (wr_first)
    );

    // Expose the target only for a granted access of the current kind.
    always_comb begin
        if ((cpu_rd && rd_grant) || (cpu_wr && wr_grant)) mem_tgt = dec_tgt;
        else                                              mem_tgt = T_NONE;
    end

    // Index, write data and write pulse go to the external memories.
    always_comb begin
        mem_idx   = dec_idx;
        mem_wdata = cpu_wdata;
        mem_we    = wr_first && wr_grant;
    end
endmodule

// File: rtl/hh_mem_map_chk.sv
`timescale 1ns/1ps
// Checker for hh_mem_map: temporal properties over ports, attached by bind.
module hh_mem_map_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_rd,
    input logic       cpu_wr,
    input logic       dma_active,
    input logic       vram_wr_ok,
    input logic [2:0] mem_tgt,
    input logic [6:0] hram_idx,
    input logic       mem_we,
    input logic [7:0] cpu_rdata
);
    AST_RESET_NO_WE: assert property (@(posedge clk) !rst_n |-> !mem_we); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_rd) |-> $stable(cpu_rdata)); // R2
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R3
    AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cpu_wr); // R3
    AST_BOOT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_tgt != 3'd1)); // R4
    AST_VRAM_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!vram_wr_ok && mem_we) |-> (mem_tgt != 3'd3)); // R5
    AST_HRAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_tgt == 3'd7) |-> (hram_idx != 7'h7F)); // R9
    AST_DMA_NO_VRAM: assert property (@(posedge clk) disable iff (!rst_n)
        dma_active |-> (mem_tgt != 3'd3)); // R12
    AST_WE_HAS_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_tgt != 3'd0)); // R12
endmodule

bind hh_mem_map hh_mem_map_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .dma_active (dma_active),
    .vram_wr_ok (vram_wr_ok),
    .mem_tgt    (mem_tgt),
    .hram_idx   (mem_idx[6:0]),
    .mem_we     (mem_we),
    .cpu_rdata  (cpu_rdata)
);

// File: tb/hh_mem_map_tb.sv
`timescale 1ns/1ps
module hh_mem_map_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;

    // Static configuration of the side inputs.
    logic        c_dma = 0, c_color = 0, c_boot_off = 0, c_perm = 1, c_dmaoam = 0;
    logic [7:0]  c_src = 8'h00, c_dbyte = 8'h00;
    logic        c_vbank = 0;
    logic [2:0]  c_wbank = 3'd0;

    logic [7:0]  boot_rdata, cart_rdata, vram_rdata, wram_rdata;
    logic [7:0]  oam_rdata, io_rdata, hram_rdata;
    logic [2:0]  mem_tgt;
    logic [15:0] mem_idx;
    logic        mem_we;
    logic [7:0]  mem_wdata, cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Arithmetic memory model: each target returns a function of code and index.
    function automatic logic [7:0] h(input int t, input logic [15:0] ix);
        return 8'(ix[7:0] ^ (ix[15:8] * 7) ^ (t * 8'h35));
    endfunction

    assign boot_rdata = h(1, mem_idx);
    assign cart_rdata = h(2, mem_idx);
    assign vram_rdata = h(3, mem_idx);
    assign wram_rdata = h(4, mem_idx);
    assign oam_rdata  = h(5, mem_idx);
    assign io_rdata   = h(6, mem_idx);
    assign hram_rdata = h(7, mem_idx);

    hh_mem_map dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .dma_active(c_dma),
        .dma_src_hi(c_src), .dma_byte(c_dbyte), .dma_oam_ok(c_dmaoam),
        .oam_rd_ok(c_perm), .oam_wr_ok(c_perm), .vram_rd_ok(c_perm),
        .vram_wr_ok(c_perm), .vram_bank(c_vbank), .wram_bank(c_wbank),
        .boot_done(c_boot_off), .color_mode(c_color),
        .boot_rdata(boot_rdata), .cart_rdata(cart_rdata), .vram_rdata(vram_rdata),
        .wram_rdata(wram_rdata), .oam_rdata(oam_rdata), .io_rdata(io_rdata),
        .hram_rdata(hram_rdata), .mem_tgt(mem_tgt), .mem_idx(mem_idx),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .cpu_rdata(cpu_rdata)
    );

    // Requirement tag for an address under the current configuration.
    function automatic string req_of(input logic [15:0] a);
        if (c_dma) begin
            if (a < 16'h8000) return "R10";
            if ((a >= 16'hA000 && a < 16'hC000) || a >= 16'hE000) return "R11";
            return "R12";
        end
        if (a < 16'h8000 || (a >= 16'hA000 && a < 16'hC000)) return "R4";
        if (a < 16'hA000) return "R5";
        if (a < 16'hFE00) return "R6";
        if (a < 16'hFEA0) return "R7";
        if (a < 16'hFF00) return "R8";
        return "R9";
    endfunction

    // Expected map from the requirements.
    task automatic model(input logic [15:0] a, output int t, output int ix,
                         output bit rg, output bit wg, output logic [7:0] cv);
        int wb;
        wb = (c_color && c_wbank != 0) ? int'(c_wbank) : 1;
        t = 0; ix = 0; rg = 0; wg = 0; cv = 8'hFF;
        if (c_dma) begin
            if (a <= 16'h7FFF) begin
                if (c_src >= 8'h80) begin t = 2; ix = a; rg = 1; end
            end else if (a >= 16'hA000 && a <= 16'hBFFF && c_color) begin
                t = 2; ix = a; rg = 1; wg = 1;
            end else if (a >= 16'hE000 && a <= 16'hEFFF) begin
                t = 4; ix = a - 16'hE000; rg = 1; wg = 1;
            end else if (a >= 16'hF000 && a <= 16'hFDFF) begin
                t = 4; ix = wb * 4096 + (a - 16'hF000); rg = 1; wg = 1;
            end else if (a >= 16'hFE00 && a <= 16'hFE9F) begin
                if (c_dmaoam) begin t = 5; ix = a - 16'hFE00; rg = 1; wg = 1; end
            end else if (a >= 16'hFF80 && a <= 16'hFFFE) begin
                t = 7; ix = a - 16'hFF80; rg = 1; wg = 1;
            end else if (a >= 16'hFF00) begin
                t = 6; ix = a - 16'hFF00; rg = 1; wg = 1;
            end else cv = c_dbyte;
        end else begin
            if (a <= 16'h7FFF) begin
                ix = a; rg = 1;
                if (!c_boot_off && (a <= 16'h00FF || (c_color && a >= 16'h0200 && a <= 16'h08FF)))
                    t = 1;
                else begin t = 2; wg = 1; end
            end else if (a <= 16'h9FFF) begin
                t = 3; ix = int'(c_vbank) * 8192 + (a - 16'h8000); rg = c_perm; wg = c_perm;
            end else if (a <= 16'hBFFF) begin
                t = 2; ix = a; rg = 1; wg = 1;
            end else if (a <= 16'hFDFF) begin
                t = 4; rg = 1; wg = 1;
                ix = (a % 4096) + (((a / 4096) % 2 == 1) ? wb * 4096 : 0);
            end else if (a <= 16'hFE9F) begin
                t = 5; ix = a - 16'hFE00; rg = c_perm; wg = c_perm;
            end else if (a <= 16'hFEFF) begin
                if (c_color) begin
                    t = 5; ix = 128 + (a % 16); rg = c_perm; wg = c_perm;
                end else cv = c_perm ? 8'h00 : 8'hFF;
            end else if (a >= 16'hFF80 && a <= 16'hFFFE) begin
                t = 7; ix = a - 16'hFF80; rg = 1; wg = 1;
            end else begin
                t = 6; ix = a - 16'hFF00; rg = 1; wg = 1;
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Read one address and compare the registered byte (R2 latency included).
    task automatic do_read(input logic [15:0] a);
        int t, ix; bit rg, wg; logic [7:0] cv, exp;
        model(a, t, ix, rg, wg, cv);
        exp = rg ? h(t, 16'(ix)) : cv;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        @(posedge clk); #1;
        check(cpu_rdata == exp, req_of(a), $sformatf("read %h", a), cpu_rdata, exp);
    endtask

    // Write one address: check the first-cycle pulse, then the held cycle (R3).
    task automatic do_write(input logic [15:0] a);
        int t, ix; bit rg, wg; logic [7:0] cv;
        model(a, t, ix, rg, wg, cv);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_wdata = a[7:0] ^ 8'h5A;
        #1;
        check(mem_we == wg, req_of(a), $sformatf("we %h", a), mem_we, wg);
        check(mem_tgt == 3'(wg ? t : 0), req_of(a), $sformatf("tgt %h", a),
              mem_tgt, wg ? t : 0);
        if (wg) begin
            check(mem_idx == 16'(ix), req_of(a), $sformatf("idx %h", a), mem_idx, ix);
            check(mem_wdata == cpu_wdata, "R3", "wdata", mem_wdata, cpu_wdata);
        end
        @(negedge clk);
        check(mem_we == 1'b0, "R3", $sformatf("held we %h", a), mem_we, 0);
        cpu_wr = 1'b0;
    endtask

    function automatic logic [15:0] edge_addr(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h00FF;  2: return 16'h0100;
            3: return 16'h01FF;  4: return 16'h0200;  5: return 16'h08FF;
            6: return 16'h0900;  7: return 16'h7FFF;  8: return 16'h8000;
            9: return 16'h9FFF; 10: return 16'hA000; 11: return 16'hBFFF;
           12: return 16'hC000; 13: return 16'hCFFF; 14: return 16'hD000;
           15: return 16'hDFFF; 16: return 16'hE000; 17: return 16'hEFFF;
           18: return 16'hF000; 19: return 16'hFDFF; 20: return 16'hFE00;
           21: return 16'hFE9F; 22: return 16'hFEA0; 23: return 16'hFEAF;
           24: return 16'hFEFF; 25: return 16'hFF00; 26: return 16'hFF7F;
           27: return 16'hFF80; 28: return 16'hFFFE; default: return 16'hFFFF;
        endcase
    endfunction

    task automatic sweep();
        for (int a = 0; a < 65536; a += 5) do_read(16'(a));
        for (int i = 0; i < 30; i++) do_read(edge_addr(i));
        for (int a = 3; a < 65536; a += 23) do_write(16'(a));
        for (int i = 0; i < 30; i++) do_write(edge_addr(i));
    endtask

    task automatic set_cfg(input bit dma, input bit color, input bit boot_off,
                           input bit perm, input bit dmaoam, input logic [7:0] src,
                           input logic [7:0] dbyte, input bit vb, input logic [2:0] wb);
        @(negedge clk);
        c_dma = dma; c_color = color; c_boot_off = boot_off; c_perm = perm;
        c_dmaoam = dmaoam; c_src = src; c_dbyte = dbyte; c_vbank = vb; c_wbank = wb;
    endtask

    initial begin
        logic [7:0] held;
        // R1: reset with a write strobe held high.
        cpu_wr = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_we == 1'b0, "R1", "we in reset", mem_we, 0);
        check(cpu_rdata == 8'h00, "R1", "rdata in reset", cpu_rdata, 0);
        cpu_wr = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_rdata == 8'h00, "R1", "rdata after reset", cpu_rdata, 0);

        // R2: the value holds while cpu_rd is low.
        do_read(16'hFF85);
        held = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h0000;
        @(posedge clk); #1;
        check(cpu_rdata == held, "R2", "hold", cpu_rdata, held);

        set_cfg(0, 0, 0, 1, 0, 8'h00, 8'h00, 1, 3'd0); sweep();
        set_cfg(0, 1, 0, 1, 0, 8'h00, 8'h00, 1, 3'd0); sweep();
        set_cfg(0, 1, 1, 0, 0, 8'h00, 8'h00, 0, 3'd5); sweep();
        set_cfg(0, 0, 1, 0, 0, 8'h00, 8'h00, 0, 3'd3); sweep();
        set_cfg(0, 1, 1, 1, 0, 8'h00, 8'h00, 0, 3'd2); sweep();
        set_cfg(1, 1, 0, 1, 1, 8'h20, 8'hA5, 1, 3'd6); sweep();
        set_cfg(1, 0, 0, 0, 0, 8'hC0, 8'h3C, 0, 3'd4); sweep();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #790000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule